// File: doc/BRIEF.md
# Synchronous Square-Wave Lock-In Demodulator

This block drives a bridge sensor with a square-wave excitation and recovers the small component of the sampled signal that follows it. The excitation is not a free-running clock. It is derived from the ADC sample strobes, so each half-period holds an exact, programmable number of samples. Every accepted sample is multiplied by the sign of the excitation: it is added while the excitation is high and subtracted while it is low. A programmable number of samples at the start of each half is skipped. This keeps switching transients out of the sum, and the same count is skipped in both halves.

The block sums over a window of a whole number of excitation periods. That makes it a boxcar (SINC1) low-pass filter with nulls at the carrier and its harmonics. A constant offset at the input therefore cancels exactly. At the end of each window the block presents the signed sum, the number of samples that contributed, and a flag that shows whether any input sample sat at a full-scale code. Changing any setting restarts the excitation and the window.

Top module: `lockin_demod`

## Requirements
- R1: After reset and after every restart, `exc_pos` is 1. It inverts after every H accepted strobes, where H is `cfg_half`, and a value of 0 is treated as 1.
- R2: An accepted sample's two's-complement value is added to the sum when `exc_pos` is 1 at that strobe and subtracted when `exc_pos` is 0.
- R3: The first D accepted strobes of every half-period contribute nothing, where D is `cfg_dead`. When D is greater than or equal to H, no sample contributes.
- R4: A window spans `cfg_periods`+1 full excitation periods. `res_valid` pulses for one cycle, on the clock after the strobe that ends the low half of the last period. The following window then starts from an empty sum.
- R5: A constant input over a whole window yields `res_sum` = 0.
- R6: `res_count` equals the number of contributing samples in the window, which is 2·(`cfg_periods`+1)·(H−D) when D < H.
- R7: `res_sat` is 1 when any accepted strobe in the window carried 0x7FFFFF or 0x800000, including blanked strobes. Otherwise it is 0. The flag starts clear in each new window.
- R8: When any configuration input differs from its value on the previous clock, the block restarts: `exc_pos` returns to 1, the partial window is discarded without a result, and a strobe in that cycle is dropped.
- R9: During reset and just after it, `exc_pos` is 1 and `res_valid`, `res_sum`, `res_count` and `res_sat` are 0.
- R10: The sum is exact for full-scale inputs at the largest window, and the result always satisfies |`res_sum`| ≤ `res_count`·2^23.
- R11: Cycles with `smp_valid` low leave the phase, the sum, the count and the saturation flag unchanged, whatever `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_half | input | 8 | Strobes per excitation half-period |
| cfg_dead | input | 6 | Strobes blanked after each excitation edge |
| cfg_periods | input | 10 | Window length in excitation periods minus one |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed sample |
| exc_pos | output | 1 | Excitation polarity, 1 = positive half |
| res_valid | output | 1 | One-cycle result strobe |
| res_sum | output | 43 | Signed demodulated window sum |
| res_count | output | 19 | Contributing samples in the window |
| res_sat | output | 1 | Full-scale code seen in the window |

## Verification
A behavioural reference model runs on every clock and is compared against the outputs. The directed cases target the places where a design typically goes wrong. If blanking were applied to one half only, a constant input would leave a non-zero residue. If the window ended on a positive half, the count would be off by a half-period. A restart that failed to discard the partial sum would add stray counts to the next result. A sticky flag that was never cleared would report saturation in a clean window. The remaining cases cover a half-period of zero, blanking that covers the whole half, idle cycles carrying full-scale garbage, and full-scale inputs of both signs over a long window. These catch a degenerate phase counter, an enable leak and a truncated accumulator.

// File: rtl/lockin_pkg.sv
package lockin_pkg;

   typedef enum logic {
      HALF_NEG = 1'b0,
      HALF_POS = 1'b1
   } half_e;

   // Bits needed to count every contributing sample of the longest window.
   function automatic int count_width(input int per_w, input int half_w);
      longint most;
      most = 2 * (longint'(1) << per_w) * ((longint'(1) << half_w) - 1);
      return $clog2(most + 1);
   endfunction

endpackage

// File: rtl/lockin_seq.sv
module lockin_seq
   import lockin_pkg::*;
#(
   parameter int HALF_W = 8,
   parameter int DEAD_W = 6,
   parameter int PER_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              strobe,
   input  logic [HALF_W-1:0] cfg_half,
   input  logic [DEAD_W-1:0] cfg_dead,
   input  logic [PER_W-1:0]  cfg_periods,
   output half_e             phase,
   output logic              take,
   output logic              last
);

   logic [HALF_W-1:0] idx;
   logic [PER_W-1:0]  per;
   logic [HALF_W-1:0] eff_half;
   logic              half_end;

   always_comb begin
      eff_half = (cfg_half == '0) ? HALF_W'(1) : cfg_half;
      half_end = (idx == eff_half - HALF_W'(1));
      take     = (int'(idx) >= int'(cfg_dead));
      last     = half_end && (phase == HALF_NEG) && (per == cfg_periods);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx   <= '0;
         per   <= '0;
         phase <= HALF_POS;
      end else if (restart) begin
         idx   <= '0;
         per   <= '0;
         phase <= HALF_POS;
      end else if (strobe) begin
         if (half_end) begin
            idx <= '0;
            if (phase == HALF_NEG) begin
               per   <= last ? '0 : per + PER_W'(1);
               phase <= HALF_POS;
            end else begin
               phase <= HALF_NEG;
            end
         end else begin
            idx <= idx + HALF_W'(1);
         end
      end
   end

endmodule

// File: rtl/lockin_acc.sv
module lockin_acc
   import lockin_pkg::*;
#(
   parameter int SW     = 24,
   parameter int CNT_W  = 19,
   parameter int ACC_W  = 43,
   parameter bit SAT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             strobe,
   input  logic [SW-1:0]    sample,
   input  logic             take,
   input  half_e            phase,
   input  logic             last,
   output logic             res_valid,
   output logic [ACC_W-1:0] res_sum,
   output logic [CNT_W-1:0] res_count,
   output logic             res_sat
);

   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] ext;
   logic signed [ACC_W-1:0] term;
   logic signed [ACC_W-1:0] acc_next;
   logic [CNT_W-1:0]        cnt;
   logic [CNT_W-1:0]        cnt_next;
   logic                    sat;
   logic                    hit;
   logic                    sat_next;

   generate
      if (SAT_EN) begin : g_sat
         assign hit = (sample == {1'b0, {(SW-1){1'b1}}}) ||
                      (sample == {1'b1, {(SW-1){1'b0}}});
      end else begin : g_nosat
         assign hit = 1'b0;
      end
   endgenerate

   always_comb begin
      ext      = {{(ACC_W-SW){sample[SW-1]}}, sample};
      term     = (phase == HALF_POS) ? ext : -ext;
      acc_next = take ? acc + term : acc;
      cnt_next = cnt + CNT_W'(take);
      sat_next = sat | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         cnt       <= '0;
         sat       <= 1'b0;
         res_valid <= 1'b0;
         res_sum   <= '0;
         res_count <= '0;
         res_sat   <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         if (restart) begin
            acc <= '0;
            cnt <= '0;
            sat <= 1'b0;
         end else if (strobe) begin
            if (last) begin
               res_valid <= 1'b1;
               res_sum   <= acc_next;
               res_count <= cnt_next;
               res_sat   <= sat_next;
               acc       <= '0;
               cnt       <= '0;
               sat       <= 1'b0;
            end else begin
               acc <= acc_next;
               cnt <= cnt_next;
               sat <= sat_next;
            end
         end
      end
   end

endmodule

// File: rtl/lockin_demod.sv
module lockin_demod
   import lockin_pkg::*;
#(
   parameter int SW     = 24,
   parameter int HALF_W = 8,
   parameter int DEAD_W = 6,
   parameter int PER_W  = 10,
   parameter bit SAT_EN = 1'b1,
   localparam int CNT_W = count_width(PER_W, HALF_W),
   localparam int ACC_W = SW + CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_W-1:0] cfg_half,
   input  logic [DEAD_W-1:0] cfg_dead,
   input  logic [PER_W-1:0]  cfg_periods,
   input  logic              smp_valid,
   input  logic [SW-1:0]     smp_data,
   output logic              exc_pos,
   output logic              res_valid,
   output logic [ACC_W-1:0]  res_sum,
   output logic [CNT_W-1:0]  res_count,
   output logic              res_sat
);

   localparam int CFG_W = HALF_W + DEAD_W + PER_W;

   generate
      if (SW < 4) begin : g_bad_sw
         $error("lockin_demod: SW must be at least 4");
      end
      if (HALF_W < 1 || PER_W < 1 || DEAD_W < 1) begin : g_bad_cfg
         $error("lockin_demod: configuration field widths must be positive");
      end
      if (HALF_W + PER_W > 40) begin : g_bad_cnt
         $error("lockin_demod: window too long for the count width");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;
   logic             primed;
   logic             restart;
   half_e            phase;
   logic             take;
   logic             last;

   assign cfg_now = {cfg_half, cfg_dead, cfg_periods};
   assign restart = primed && (cfg_now != cfg_q);
   assign exc_pos = (phase == HALF_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         primed <= 1'b0;
      end else begin
         cfg_q  <= cfg_now;
         primed <= 1'b1;
      end
   end

   lockin_seq #(
      .HALF_W (HALF_W),
      .DEAD_W (DEAD_W),
      .PER_W  (PER_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (restart),
      .strobe      (smp_valid),
      .cfg_half    (cfg_half),
      .cfg_dead    (cfg_dead),
      .cfg_periods (cfg_periods),
      .phase       (phase),
      .take        (take),
      .last        (last)
   );

   lockin_acc #(
      .SW     (SW),
      .CNT_W  (CNT_W),
      .ACC_W  (ACC_W),
      .SAT_EN (SAT_EN)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .strobe    (smp_valid),
      .sample    (smp_data),
      .take      (take),
      .phase     (phase),
      .last      (last),
      .res_valid (res_valid),
      .res_sum   (res_sum),
      .res_count (res_count),
      .res_sat   (res_sat)
   );

endmodule

// File: rtl/lockin_chk.sv
module lockin_chk #(
   parameter int SW     = 24,
   parameter int HALF_W = 8,
   parameter int PER_W  = 10,
   parameter int CNT_W  = 19,
   parameter int ACC_W  = 43
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic              restart,
   input logic [HALF_W-1:0] cfg_half,
   input logic [PER_W-1:0]  cfg_periods,
   input logic              exc_pos,
   input logic              res_valid,
   input logic [ACC_W-1:0]  res_sum,
   input logic [CNT_W-1:0]  res_count
);

   logic [ACC_W-1:0] mag;
   logic [ACC_W:0]   lim;
   logic [CNT_W:0]   cnt_cap;
   int               eff;

   always_comb begin
      mag     = res_sum[ACC_W-1] ? (~res_sum + ACC_W'(1)) : res_sum;
      lim     = (ACC_W+1)'(res_count) << (SW-1);
      eff     = (cfg_half == '0) ? 1 : int'(cfg_half);
      cnt_cap = (CNT_W+1)'(2 * (int'(cfg_periods) + 1) * eff);
   end

   // R1: polarity moves only on a strobe or a restart
   a_r1_exc_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(exc_pos) |-> ($past(smp_valid) || $past(restart)));

   // R4: a result follows an accepted strobe
   a_r4_result_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(smp_valid) && !$past(restart)));

   // R4: result strobe lasts one cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R8: restart returns the excitation to its positive half
   a_r8_restart_positive: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> exc_pos);

   // R6: the count never exceeds the window's strobe total
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (CNT_W+1)'(res_count) <= $past(cnt_cap));

   // R10: no wrap of the sum
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ((ACC_W+1)'(mag) <= lim));

endmodule

bind lockin_demod lockin_chk #(
   .SW     (SW),
   .HALF_W (HALF_W),
   .PER_W  (PER_W),
   .CNT_W  (CNT_W),
   .ACC_W  (ACC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid   (smp_valid),
   .restart     (restart),
   .cfg_half    (cfg_half),
   .cfg_periods (cfg_periods),
   .exc_pos     (exc_pos),
   .res_valid   (res_valid),
   .res_sum     (res_sum),
   .res_count   (res_count)
);

// File: tb/tb_lockin_demod.sv
module tb_lockin_demod;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_half = 8'd48;
   logic [5:0]  cfg_dead = 6'd3;
   logic [9:0]  cfg_periods = 10'd63;
   logic        smp_valid = 1'b0;
   logic [23:0] smp_data = '0;
   logic        exc_pos;
   logic        res_valid;
   logic [42:0] res_sum;
   logic [18:0] res_count;
   logic        res_sat;

   always #5 clk = ~clk;

   lockin_demod dut (
      .clk (clk), .rst_n (rst_n),
      .cfg_half (cfg_half), .cfg_dead (cfg_dead), .cfg_periods (cfg_periods),
      .smp_valid (smp_valid), .smp_data (smp_data),
      .exc_pos (exc_pos), .res_valid (res_valid), .res_sum (res_sum),
      .res_count (res_count), .res_sat (res_sat)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string req, input longint got, input longint exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   // behavioural reference model
   bit     m_pos = 1, m_valid = 0, m_sat = 0, m_rsat = 0, primed = 0;
   int     m_idx = 0, m_per = 0, m_cnt = 0, m_rcnt = 0;
   longint m_acc = 0, m_rsum = 0;
   int     p_half = 0, p_dead = 0, p_per = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 1; m_idx = 0; m_per = 0; m_acc = 0; m_cnt = 0; m_sat = 0;
         m_valid = 0; m_rsum = 0; m_rcnt = 0; m_rsat = 0; primed = 0;
      end else begin
         int h;
         longint s;
         bit restart;
         m_valid = 0;
         restart = primed && (p_half != cfg_half || p_dead != cfg_dead || p_per != cfg_periods);
         primed = 1; p_half = cfg_half; p_dead = cfg_dead; p_per = cfg_periods;
         if (restart) begin
            m_pos = 1; m_idx = 0; m_per = 0; m_acc = 0; m_cnt = 0; m_sat = 0;
         end else if (smp_valid) begin
            h = (cfg_half == 0) ? 1 : cfg_half;
            s = longint'($signed(smp_data));
            if (smp_data == 24'h7FFFFF || smp_data == 24'h800000) m_sat = 1;
            if (m_idx >= cfg_dead) begin
               m_acc += m_pos ? s : -s;
               m_cnt++;
            end
            m_idx++;
            if (m_idx == h) begin
               m_idx = 0;
               if (!m_pos) begin
                  if (m_per == cfg_periods) begin
                     m_valid = 1; m_rsum = m_acc; m_rcnt = m_cnt; m_rsat = m_sat;
                     m_acc = 0; m_cnt = 0; m_sat = 0; m_per = 0;
                  end else m_per++;
               end
               m_pos = !m_pos;
            end
         end
      end
   end

   longint cap_sum = 0;
   int     cap_cnt = 0, cap_n = 0;
   bit     cap_sat = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 excitation", exc_pos, m_pos);
         chk("R4 result strobe", res_valid, m_valid);
         if (m_valid) begin
            chk("R2 sum", longint'($signed(res_sum)), m_rsum);
            chk("R6 count", res_count, m_rcnt);
            chk("R7 flag", res_sat, m_rsat);
         end
         if (res_valid) begin
            cap_sum = longint'($signed(res_sum));
            cap_cnt = res_count; cap_sat = res_sat; cap_n++;
         end
      end
   end

   task automatic drive(input bit v, input logic [23:0] d);
      @(negedge clk);
      smp_valid = v;
      smp_data  = d;
   endtask

   task automatic run_mod(input int n, input int a, input int b, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_valid = 1'b1;
         smp_data  = exc_pos ? 24'(a) : 24'(b);
         for (int g = 0; g < gap; g++) drive(0, 24'h7FFFFF);
      end
   endtask

   task automatic settle();
      drive(0, 24'h0);
      drive(0, 24'h0);
   endtask

   task automatic setcfg(input int h, input int d, input int p);
      @(negedge clk);
      smp_valid = 0;
      cfg_half = 8'(h); cfg_dead = 6'(d); cfg_periods = 10'(p);
      settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk("R9 reset exc", exc_pos, 1);
      chk("R9 reset valid", res_valid, 0);
      chk("R9 reset sum", res_sum, 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R9 post-reset exc", exc_pos, 1);
      chk("R9 post-reset count", res_count, 0);
      chk("R9 post-reset flag", res_sat, 0);

      // R2 R3 R6: H=8, D=2, three periods, modulated input
      setcfg(8, 2, 2);
      base = cap_n;
      run_mod(48, 1000, -1000, 0); settle();
      chk("R4 one result", cap_n, base + 1);
      chk("R2 modulated sum", cap_sum, 36000);
      chk("R3 blanked count", cap_cnt, 36);

      // R5: constant input cancels
      run_mod(48, 5000, 5000, 0); settle();
      chk("R5 constant rejected", cap_sum, 0);

      // R11: idle cycles carry full-scale garbage
      run_mod(48, 300, -100, 2); settle();
      chk("R11 gapped sum", cap_sum, 7200);
      chk("R11 garbage ignored flag", cap_sat, 0);
      chk("R6 gapped count", cap_cnt, 36);

      // R7: saturation set then cleared
      run_mod(10, 1, 1, 0); drive(1, 24'h800000); run_mod(37, 1, 1, 0); settle();
      chk("R7 flag set", cap_sat, 1);
      run_mod(48, 1, 1, 0); settle();
      chk("R7 flag cleared", cap_sat, 0);

      // R3: dead time covers whole half
      setcfg(4, 5, 0);
      run_mod(8, 77, -77, 0); settle();
      chk("R3 all blanked count", cap_cnt, 0);
      chk("R3 all blanked sum", cap_sum, 0);

      // R1: half of zero acts as one
      setcfg(0, 0, 1);
      base = cap_n;
      run_mod(4, 7, -3, 0); settle();
      chk("R1 zero half result", cap_n, base + 1);
      chk("R1 zero half sum", cap_sum, 20);

      // R8: restart mid-window
      setcfg(8, 2, 2);
      base = cap_n;
      run_mod(20, 500, -500, 0);
      @(negedge clk); smp_valid = 0; cfg_dead = 6'd1;
      drive(0, 0);
      chk("R8 exc after restart", exc_pos, 1);
      run_mod(48, 10, -10, 0); settle();
      chk("R8 partial discarded", cap_n, base + 1);
      chk("R8 fresh count", cap_cnt, 42);
      chk("R8 fresh sum", cap_sum, 420);

      // R10: full-scale over a long window at default half
      setcfg(48, 3, 63);
      run_mod(6144, 32'h800000, 32'h7FFFFF, 0); settle();
      chk("R10 full-scale count", cap_cnt, 5760);
      chk("R10 full-scale sum", cap_sum, -longint'(16777215) * 2880);
      chk("R7 full-scale flag", cap_sat, 1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule